// File: doc/BRIEF.md
# Glitch-Free Two-Input Clock Selector with Stopped-Clock Detection

This block picks one of two incoming clocks and fans the chosen clock out to two banks of outputs. A change of the select input never produces a runt pulse: the clock that is currently driving is shut off on one of its own low phases, and only after that does the newly chosen clock open, also on one of its own low phases. A stop monitor clocked by a free-running reference watches each input. When an input has held one level for a set number of reference cycles, that input is marked as lost. A lost input is forced out of the handoff, so a switch away from a dead clock still completes.

Each bank can pass the selected clock unchanged or halve its frequency. The halving flop restarts from zero whenever the bank's mode changes, so the first divided pulse is a full one. Every output has its own enable. The enable is sampled on a falling edge of that bank's clock, so turning an output on or off never cuts a pulse short. A disabled output is held low.

Top module: `clk_switch_fanout`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, every output of both banks and both lost flags are 0, and both input gates are closed. After reset, the input chosen by `clk_sel` is the first one opened.
- R2: With `clk_sel` = 0 the banks carry `clk_in0`. With `clk_sel` = 1 they carry `clk_in1`. Once the handoff has settled, the output period equals the period of the chosen input.
- R3: Across select changes, divide-mode changes and enable changes, no output high time or low time is shorter than the shorter half-period of the two inputs.
- R4: `lost0`/`lost1` rises once the matching input has shown no edge for `STOP_CYCLES` reference cycles, plus up to four cycles of sampling latency. It stays 0 while that input has been quiet for clearly fewer cycles than that.
- R5: A lost flag returns to 0 within a few reference cycles after edges resume on its input.
- R6: When the driving input stops, stuck high or stuck low, and the select moves to the other input, the banks go on to carry the other input.
- R7: `half_a`/`half_b` = 1 makes that bank run at half the selected frequency, and 0 passes the selected clock unchanged. The two banks are set independently.
- R8: After a bank's divide control changes from 0 to 1, its first output pulse wider than an undivided pulse lasts exactly one full period of the selected input.
- R9: An output whose enable bit is 0 stays low. An output whose enable bit is 1 toggles with its bank clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for the stop monitors |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_in0 | input | 1 | Clock input chosen when clk_sel is 0 |
| clk_in1 | input | 1 | Clock input chosen when clk_sel is 1 |
| clk_sel | input | 1 | Input select |
| half_a | input | 1 | Bank A divide-by-2 when 1 |
| half_b | input | 1 | Bank B divide-by-2 when 1 |
| oe_a | input | BANK_W | Per-output enables of bank A |
| oe_b | input | BANK_W | Per-output enables of bank B |
| q_a | output | BANK_W | Bank A clock outputs |
| q_b | output | BANK_W | Bank B clock outputs |
| lost0 | output | 1 | clk_in0 declared stopped |
| lost1 | output | 1 | clk_in1 declared stopped |

## Verification
The hardest overlap is an input handoff that coincides with a divide-mode change or an enable change. All three act on the same falling edges of the selected clock, and a pulse could be clipped between them. Random sequences of select, divide and enable settings are applied with a fixed seed. A timing monitor measures every high and low interval on all eight outputs and flags any interval shorter than the smaller input half-period. Periods and enable states after each change are compared with values worked out from the chosen input and mode. Directed cases stop the driving clock both high and low, with and without a switch underway.

// File: rtl/clk_switch_fanout.sv
`timescale 1ns/1ps
module clk_switch_fanout #(
  parameter int BANK_W      = 4,
  parameter int STOP_CYCLES = 50
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              clk_in0,
  input  logic              clk_in1,
  input  logic              clk_sel,
  input  logic              half_a,
  input  logic              half_b,
  input  logic [BANK_W-1:0] oe_a,
  input  logic [BANK_W-1:0] oe_b,
  output logic [BANK_W-1:0] q_a,
  output logic [BANK_W-1:0] q_b,
  output logic              lost0,
  output logic              lost1
);
  localparam int CW = $clog2(STOP_CYCLES + 1);

  logic [1:0] clk_in;
  logic [1:0] lost;
  assign clk_in = {clk_in1, clk_in0};

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_mon
      logic [2:0]    smp;
      logic [CW-1:0] cnt;
      logic          bad;
      logic          seen;
      assign seen = smp[2] ^ smp[1];
      always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
          smp <= '0;
          cnt <= '0;
          bad <= 1'b0;
        end else begin
          smp <= {smp[1:0], clk_in[gi]};
          if (seen) begin
            cnt <= '0;
            bad <= 1'b0;
          end else if (cnt == CW'(STOP_CYCLES)) begin
            bad <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
      assign lost[gi] = bad;
    end
  endgenerate

  assign lost0 = lost[0];
  assign lost1 = lost[1];

  logic       rst0_n, rst1_n;
  logic [1:0] p0, p1;
  logic       req0, req1;
  logic       sel_clk;

  assign rst0_n = rst_n & ~lost[0];
  assign rst1_n = rst_n & ~lost[1];
  assign req0   = ~clk_sel & ~p1[0] & ~p1[1];
  assign req1   =  clk_sel & ~p0[0] & ~p0[1];

  always_ff @(negedge clk_in0 or negedge rst0_n)
    if (!rst0_n) p0 <= 2'b00;
    else         p0 <= {p0[0], req0};

  always_ff @(negedge clk_in1 or negedge rst1_n)
    if (!rst1_n) p1 <= 2'b00;
    else         p1 <= {p1[0], req1};

  assign sel_clk = (clk_in0 & p0[1]) | (clk_in1 & p1[1]);

  logic [1:0]          half;
  logic [2*BANK_W-1:0] oe_all;
  logic [2*BANK_W-1:0] q_all;
  assign half   = {half_b, half_a};
  assign oe_all = {oe_b, oe_a};

  generate
    for (gi = 0; gi < 2; gi++) begin : g_bank
      logic [1:0]        hs;
      logic              mode;
      logic              tog;
      logic              bclk;
      logic [BANK_W-1:0] en_q;

      always_ff @(posedge sel_clk or negedge rst_n)
        if (!rst_n) hs <= 2'b00;
        else        hs <= {hs[0], half[gi]};

      always_ff @(negedge sel_clk or negedge rst_n)
        if (!rst_n) mode <= 1'b0;
        else        mode <= hs[1];

      always_ff @(posedge sel_clk or negedge rst_n)
        if (!rst_n) tog <= 1'b0;
        else        tog <= mode ? ~tog : 1'b0;

      assign bclk = mode ? tog : sel_clk;

      always_ff @(negedge bclk or negedge rst_n)
        if (!rst_n) en_q <= '0;
        else        en_q <= oe_all[gi*BANK_W +: BANK_W];

      assign q_all[gi*BANK_W +: BANK_W] = {BANK_W{bclk}} & en_q;
    end
  endgenerate

  assign q_a = q_all[BANK_W-1:0];
  assign q_b = q_all[2*BANK_W-1:BANK_W];
endmodule

module clk_switch_fanout_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic gate0,
  input logic gate1,
  input logic lost0,
  input logic lost1,
  input logic s0a,
  input logic s0b,
  input logic s1a,
  input logic s1b
);
  AST_GATES_EXCLUSIVE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(gate0 && gate1)); // R3
  AST_LOST0_GATE_SHUT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    lost0 |=> (!gate0 || !lost0)); // R6
  AST_LOST1_GATE_SHUT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    lost1 |=> (!gate1 || !lost1)); // R6
  AST_LOST0_AFTER_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(lost0) |-> $past(s0a == s0b)); // R4
  AST_LOST1_AFTER_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(lost1) |-> $past(s1a == s1b)); // R4
  AST_LOST0_CLEARS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (lost0 && (s0a != s0b)) |=> !lost0); // R5
  AST_LOST1_CLEARS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (lost1 && (s1a != s1b)) |=> !lost1); // R5
endmodule

bind clk_switch_fanout clk_switch_fanout_chk u_chk (
  .ref_clk(ref_clk),
  .rst_n  (rst_n),
  .gate0  (p0[1]),
  .gate1  (p1[1]),
  .lost0  (lost[0]),
  .lost1  (lost[1]),
  .s0a    (g_mon[0].smp[1]),
  .s0b    (g_mon[0].smp[2]),
  .s1a    (g_mon[1].smp[1]),
  .s1b    (g_mon[1].smp[2])
);

// File: tb/test_clk_switch_fanout.sv
`timescale 1ns/1ps
module test_clk_switch_fanout;
  localparam int  BW    = 4;
  localparam real P0    = 10.0;
  localparam real P1    = 14.0;
  localparam real MINW  = 5.0;

  logic ref_clk = 1'b0, rst_n = 1'b0, clk0 = 1'b0, clk1 = 1'b0;
  logic sel = 1'b0, half_a = 1'b0, half_b = 1'b0;
  logic [BW-1:0] oe_a = '1, oe_b = '1, q_a, q_b;
  logic lost0, lost1;
  bit run0 = 1'b1, run1 = 1'b1;
  int checks = 0, errors = 0, glitches = 0;
  bit done = 1'b0;

  clk_switch_fanout #(.BANK_W(BW), .STOP_CYCLES(50)) i_clk_switch_fanout (
    .ref_clk(ref_clk), .rst_n(rst_n), .clk_in0(clk0), .clk_in1(clk1),
    .clk_sel(sel), .half_a(half_a), .half_b(half_b), .oe_a(oe_a), .oe_b(oe_b),
    .q_a(q_a), .q_b(q_b), .lost0(lost0), .lost1(lost1));

  always #2 ref_clk = ~ref_clk;
  initial forever begin #(P0/2); if (run0) clk0 = ~clk0; end
  initial begin #1.3; forever begin #(P1/2); if (run1) clk1 = ~clk1; end end

  // R3 monitor: every high and low interval on all outputs
  real last_t [2*BW];
  logic [2*BW-1:0] prev_q = '0;
  initial for (int i = 0; i < 2*BW; i++) last_t[i] = -1.0;
  always @(q_a or q_b) begin
    for (int i = 0; i < 2*BW; i++) begin
      if ({q_b, q_a}[i] !== prev_q[i]) begin
        if (rst_n && last_t[i] >= 0.0 && ($realtime - last_t[i]) < MINW - 0.01) glitches++;
        last_t[i] = $realtime;
      end
    end
    prev_q = {q_b, q_a};
  end

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic period_a(output real p);
    real t1;
    @(posedge q_a[0]); t1 = $realtime;
    @(posedge q_a[0]); p = $realtime - t1;
  endtask

  task automatic period_b(output real p);
    real t1;
    @(posedge q_b[0]); t1 = $realtime;
    @(posedge q_b[0]); p = $realtime - t1;
  endtask

  // sample a bank A bit for a window; returns 1 if ever high
  task automatic seen_high_a(input int b, output bit hi);
    hi = 1'b0;
    for (int k = 0; k < 80; k++) begin
      #1;
      if (q_a[b]) hi = 1'b1;
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    report();
  end

  initial begin
    real p, t1, w;
    bit hi, got;
    void'($urandom(32'd4242));
    // R1 reset state
    #53;
    chk(q_a == '0 && q_b == '0, "R1 outputs in reset", real'({q_b, q_a}), 0.0);
    chk(!lost0 && !lost1, "R1 lost flags in reset", real'({lost1, lost0}), 0.0);
    rst_n = 1'b1;
    #300;
    // R1/R2 selected input opens first
    period_a(p); chk(near(p, P0), "R1 R2 bank A period sel0", p, P0);
    period_b(p); chk(near(p, P0), "R2 bank B period sel0", p, P0);
    sel = 1'b1; #400;
    period_a(p); chk(near(p, P1), "R2 bank A period sel1", p, P1);
    // R7 independent banks
    half_a = 1'b1; #300;
    period_a(p); chk(near(p, 2*P1), "R7 bank A halved", p, 2*P1);
    period_b(p); chk(near(p, P1), "R7 bank B undivided", p, P1);
    half_a = 1'b0;
    // R8 first wide pulse is full width
    #200;
    @(negedge q_b[0]); half_b = 1'b1;
    got = 1'b0; w = 0.0;
    for (int k = 0; k < 12 && !got; k++) begin
      @(posedge q_b[0]); t1 = $realtime;
      @(negedge q_b[0]); w = $realtime - t1;
      if (w > P1/2 + 0.5) got = 1'b1;
    end
    chk(got && near(w, P1), "R8 first divided pulse width", w, P1);
    half_b = 1'b0; #300;
    // R9 enable
    oe_a[2] = 1'b0; #100;
    seen_high_a(2, hi); chk(!hi, "R9 disabled output low", real'(hi), 0.0);
    seen_high_a(1, hi); chk(hi, "R9 enabled output toggles", real'(hi), 1.0);
    oe_a[2] = 1'b1; #100;
    seen_high_a(2, hi); chk(hi, "R9 re-enabled output toggles", real'(hi), 1.0);
    // R4/R5 unselected clk0 stuck low
    @(negedge clk0); run0 = 1'b0;
    #150; chk(!lost0, "R4 lost0 not yet set", real'(lost0), 0.0);
    #150; chk(lost0, "R4 lost0 set after quiet", real'(lost0), 1.0);
    chk(!lost1, "R4 lost1 stays clear", real'(lost1), 0.0);
    period_a(p); chk(near(p, P1), "R6 selected path unaffected", p, P1);
    run0 = 1'b1; #100;
    chk(!lost0, "R5 lost0 clears", real'(lost0), 0.0);
    // R6 driving clk1 stuck high, switch away
    #300;
    @(posedge clk1); run1 = 1'b0;
    sel = 1'b0;
    #600;
    chk(lost1, "R6 lost1 set", real'(lost1), 1.0);
    period_a(p); chk(near(p, P0), "R6 handoff past stuck-high clock", p, P0);
    run1 = 1'b1; #100;
    chk(!lost1, "R5 lost1 clears", real'(lost1), 0.0);
    // R6 driving clk0 stuck low, switch away
    #300;
    @(negedge clk0); run0 = 1'b0;
    sel = 1'b1;
    #600;
    period_b(p); chk(near(p, P1), "R6 handoff past stuck-low clock", p, P1);
    run0 = 1'b1; #300;
    // random mix: select, divide and enable changes together (R2 R3 R7 R9)
    for (int it = 0; it < 40; it++) begin
      real ep;
      logic [BW-1:0] na;
      sel    = 1'($urandom);
      half_a = 1'($urandom);
      half_b = 1'($urandom);
      na     = BW'($urandom) | BW'(1);
      oe_a   = na;
      oe_b   = BW'($urandom) | BW'(1);
      #(400 + ($urandom % 50));
      ep = sel ? P1 : P0;
      period_a(p); chk(near(p, half_a ? 2*ep : ep), "R2 R7 random bank A period", p, half_a ? 2*ep : ep);
      period_b(p); chk(near(p, half_b ? 2*ep : ep), "R2 R7 random bank B period", p, half_b ? 2*ep : ep);
      seen_high_a(3, hi); chk(hi == na[3], "R9 random enable bit 3", real'(hi), real'(na[3]));
    end
    chk(glitches == 0, "R3 short pulses on outputs", real'(glitches), 0.0);
    report();
  end
endmodule